// File: doc/BRIEF.md
# Dual-Compare 8-bit PWM Timer

An 8-bit counter runs on a clock enable chosen from two sources: a strobe from an outside prescaler, or a synchronized and edge-detected external pin. Two compare channels watch the counter. Each channel drives one waveform pin. Together they support four operating styles: free-running counting, counting that clears on a compare-A match (auto-reload with a variable period), frequency generation by toggling on each match, and phase-correct PWM. In phase-correct PWM the counter sweeps up to TOP and back down to zero, so the pulse edges stay symmetric and glitch-free.

Software reaches the timer through a write-only register port. The port loads the counter, the two buffered compare values, a control byte, an interrupt mask and a power-reduction bit. It also clears interrupt flags by writing ones. Three event flags are kept: overflow, compare-A and compare-B. Each flag produces an interrupt request only while its mask bit is one. While the power-reduction bit is set, the timer stands still.

Top module: `tmr8_dual`

## Requirements
- R1: After reset, the counter, both waveform pins, the three flags and the three requests are all zero.
- R2: With mode code 0 (control bits [1:0] = 00, free-running), each enabled tick adds one to the counter, and 0xFF wraps to 0x00. A tick taken at 0xFF sets the overflow flag (flag bit 0).
- R3: With mode code 1 (clear on compare), a tick taken while the counter equals active compare A loads 0 instead of incrementing.
- R4: In modes 0 and 1, a channel's action field (bits [5:4] for A, [7:6] for B) acts on its own match tick as follows: 01 toggles the pin, 10 clears it and 11 sets it. With field 00 the pin reads 0.
- R5: Modes 2 and 3 count up to TOP, then down to 0, then up again. TOP is 0xFF in mode 2 and active compare A in mode 3. A tick taken at 0 while counting down sets the overflow flag.
- R6: In modes 2 and 3, action 10 clears the pin on a match while counting up and sets it on a match while counting down. Action 11 does the reverse, and action 01 leaves the pin unchanged.
- R7: Writes to address 2 (compare A) and address 3 (compare B) land in a buffer. In modes 0 and 1 the active value follows the buffer on the same edge. In modes 2 and 3 the active value changes only on a tick taken at TOP.
- R8: The clock-select field (bits [3:2]) works as follows. 00 stops the counter. 01 counts on each cycle that has the prescaler strobe high. 10 counts rising edges of the external pin and 11 counts falling edges. A pin edge moves the counter on the third rising clock edge after it.
- R9: While the power-reduction bit (address 6, bit 0) is one, the counter takes no ticks and no flag gets set.
- R10: A flag is set on the edge that ends its event's tick (bit 1 for a compare-A match, bit 2 for a compare-B match). Writing a one at address 5 clears that flag. If an event and a clear fall on the same edge, the event wins.
- R11: Each request equals its flag ANDed with the mask bit at address 4 (bits [2:0]).
- R12: Writing address 1 loads the counter on the next edge. That cycle takes no count and raises no match or overflow event. Address 0 holds the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_tick_i | input | 1 | Prescaler strobe |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | CNT_W | Register write data |
| cnt_o | output | CNT_W | Current counter value |
| wave_a_o | output | 1 | Channel A waveform pin |
| wave_b_o | output | 1 | Channel B waveform pin |
| flag_o | output | 3 | Event flags {B, A, overflow} |
| irq_o | output | 3 | Masked interrupt requests |

## Verification
Several rules are checked every cycle by properties:
- the single-step increment in free-running mode;
- the return to zero on a compare-A match in clear mode;
- the turn to down-counting at TOP;
- the frozen active compare A between TOP ticks in PWM modes;
- the counter standing still under power reduction;
- the rule that no flag rises without its event.

The waveform shapes under each action code, the three-edge latency of the external pin, and the event-over-clear priority can only be shown by the bench's scenarios. Those scenarios match every output against the reference model through mode switches and mid-period compare rewrites.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'b00,
    MODE_CLR     = 2'b01,
    MODE_PC_FULL = 2'b10,
    MODE_PC_CMPA = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    CLK_OFF      = 2'b00,
    CLK_PRESC    = 2'b01,
    CLK_EXT_RISE = 2'b10,
    CLK_EXT_FALL = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    WAVE_OFF    = 2'b00,
    WAVE_TOGGLE = 2'b01,
    WAVE_CLEAR  = 2'b10,
    WAVE_SET    = 2'b11
  } wave_act_e;

  typedef struct packed {
    wave_act_e act_b;
    wave_act_e act_a;
    clk_src_e  csel;
    tmr_mode_e mode;
  } tmr_ctrl_t;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_CNT  = 3'd1;
  localparam logic [2:0] ADDR_CMPA = 3'd2;
  localparam logic [2:0] ADDR_CMPB = 3'd3;
  localparam logic [2:0] ADDR_MASK = 3'd4;
  localparam logic [2:0] ADDR_FLAG = 3'd5;
  localparam logic [2:0] ADDR_PWR  = 3'd6;

  localparam int unsigned N_EVT = 3;

endpackage

// File: rtl/tmr_clk_sel.sv
`timescale 1ns/1ps
module tmr_clk_sel
  import tmr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ext_i,
  input  logic     presc_i,
  input  clk_src_e csel_i,
  input  logic     hold_i,
  output logic     tick_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_s;
  logic                   src;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= ext_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_s;
  end

  always_comb begin
    case (csel_i)
      CLK_PRESC:    src = presc_i;
      CLK_EXT_RISE: src = pin_s & ~prev_q;
      CLK_EXT_FALL: src = ~pin_s & prev_q;
      default:      src = 1'b0;
    endcase
  end

  // synchronizer keeps sampling under hold so release makes no false edge
  assign tick_o = src & ~hold_i;

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  tmr_mode_e        mode_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmpa_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             down_o,
  output logic [CNT_W-1:0] top_o,
  output logic             step_o,
  output logic             top_hit_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             down_q;
  logic             pwm;

  assign pwm       = mode_i[1];
  assign top_o     = (mode_i == MODE_PC_CMPA) ? cmpa_i : CNT_MAX;
  assign step_o    = tick_i & ~load_i;
  assign top_hit_o = step_o & pwm & (cnt_q == top_o);
  assign ovf_o     = step_o & (pwm ? (down_q & (cnt_q == '0)) : (cnt_q == CNT_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i) begin
      case (mode_i)
        MODE_FREE: begin
          cnt_q  <= cnt_q + CNT_ONE;
          down_q <= 1'b0;
        end
        MODE_CLR: begin
          cnt_q  <= (cnt_q == cmpa_i) ? '0 : cnt_q + CNT_ONE;
          down_q <= 1'b0;
        end
        default: begin
          if (top_o == '0) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
          end else if (!down_q) begin
            if (cnt_q >= top_o) begin
              cnt_q  <= cnt_q - CNT_ONE;
              down_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + CNT_ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_q  <= CNT_ONE;
              down_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q - CNT_ONE;
            end
          end
        end
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign down_o = down_q;

endmodule

// File: rtl/tmr_cmp_unit.sv
`timescale 1ns/1ps
module tmr_cmp_unit
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             down_i,
  input  logic             pwm_i,
  input  logic             top_hit_i,
  input  logic             buf_wr_i,
  input  logic [CNT_W-1:0] buf_val_i,
  input  wave_act_e        act_i,
  output logic [CNT_W-1:0] ocr_o,
  output logic             match_o,
  output logic             wave_o
);

  logic [CNT_W-1:0] buf_q;
  logic [CNT_W-1:0] ocr_q;
  logic             wave_q;
  logic             wave_d;

  assign match_o = step_i & (cnt_i == ocr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      ocr_q <= '0;
    end else begin
      if (buf_wr_i) buf_q <= buf_val_i;
      if (!pwm_i)         ocr_q <= buf_wr_i ? buf_val_i : buf_q;
      else if (top_hit_i) ocr_q <= buf_q;
    end
  end

  always_comb begin
    wave_d = wave_q;
    if (match_o) begin
      if (!pwm_i) begin
        case (act_i)
          WAVE_TOGGLE: wave_d = ~wave_q;
          WAVE_CLEAR:  wave_d = 1'b0;
          WAVE_SET:    wave_d = 1'b1;
          default:     wave_d = wave_q;
        endcase
      end else begin
        case (act_i)
          WAVE_CLEAR: wave_d = down_i;
          WAVE_SET:   wave_d = ~down_i;
          default:    wave_d = wave_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_d;
  end

  assign ocr_o  = ocr_q;
  assign wave_o = (act_i != WAVE_OFF) & wave_q;

endmodule

// File: rtl/tmr_irq.sv
`timescale 1ns/1ps
module tmr_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] irq_o
);

  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (evt_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & mask_i;

endmodule

// File: rtl/tmr8_dual.sv
`timescale 1ns/1ps
module tmr8_dual
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             presc_tick_i,
  input  logic             ext_clk_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wave_a_o,
  output logic             wave_b_o,
  output logic [2:0]       flag_o,
  output logic [2:0]       irq_o
);

  localparam int unsigned N_CMP = 2;

  tmr_ctrl_t        ctrl_q;
  logic [N_EVT-1:0] mask_q;
  logic             pwr_q;

  logic             tick;
  logic             load;
  logic             step;
  logic             down;
  logic             top_hit;
  logic             ovf;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] top;
  logic [N_EVT-1:0] evt;
  logic [N_EVT-1:0] clr;

  logic [CNT_W-1:0] ocr   [N_CMP];
  logic             match [N_CMP];
  logic             wave  [N_CMP];
  wave_act_e        acts  [N_CMP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
      pwr_q  <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_CTRL: ctrl_q <= tmr_ctrl_t'(wr_data_i[7:0]);
        ADDR_MASK: mask_q <= wr_data_i[N_EVT-1:0];
        ADDR_PWR:  pwr_q  <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  assign load = wr_en_i && (wr_addr_i == ADDR_CNT);
  assign clr  = (wr_en_i && (wr_addr_i == ADDR_FLAG)) ? wr_data_i[N_EVT-1:0] : '0;

  tmr_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) u_clk_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ext_i   (ext_clk_i),
    .presc_i (presc_tick_i),
    .csel_i  (ctrl_q.csel),
    .hold_i  (pwr_q),
    .tick_o  (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .mode_i     (ctrl_q.mode),
    .load_i     (load),
    .load_val_i (wr_data_i),
    .cmpa_i     (ocr[0]),
    .cnt_o      (cnt),
    .down_o     (down),
    .top_o      (top),
    .step_o     (step),
    .top_hit_o  (top_hit),
    .ovf_o      (ovf)
  );

  assign acts[0] = ctrl_q.act_a;
  assign acts[1] = ctrl_q.act_b;

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    tmr_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (step),
      .cnt_i     (cnt),
      .down_i    (down),
      .pwm_i     (ctrl_q.mode[1]),
      .top_hit_i (top_hit),
      .buf_wr_i  (wr_en_i && (wr_addr_i == ADDR_CMPA + 3'(g))),
      .buf_val_i (wr_data_i),
      .act_i     (acts[g]),
      .ocr_o     (ocr[g]),
      .match_o   (match[g]),
      .wave_o    (wave[g])
    );
  end

  assign evt = {match[1], match[0], ovf};

  tmr_irq #(.N(N_EVT)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (clr),
    .mask_i (mask_q),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );

  assign cnt_o    = cnt;
  assign wave_a_o = wave[0];
  assign wave_b_o = wave[1];

endmodule

// File: rtl/tmr8_dual_chk.sv
`timescale 1ns/1ps
module tmr8_dual_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input tmr_mode_e        mode_i,
  input logic             tick_i,
  input logic             load_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             down_i,
  input logic [CNT_W-1:0] top_i,
  input logic             top_hit_i,
  input logic [CNT_W-1:0] ocra_i,
  input logic             pwr_i,
  input logic [2:0]       evt_i,
  input logic [2:0]       flag_i
);

  assert_free_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FREE) && tick_i && !load_i |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  assert_clr_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CLR) && tick_i && !load_i && (cnt_i == ocra_i) |=> cnt_i == '0);

  assert_turn_at_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] && tick_i && !load_i && (cnt_i == top_i) && (top_i != '0) |=> down_i);

  assert_cmp_buffered_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] && !top_hit_i |=> $stable(ocra_i));

  assert_power_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_i && !load_i |=> $stable(cnt_i));

  assert_ovf_flag_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i[0] |=> !$rose(flag_i[0]));

  assert_cmpa_flag_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i[1] |=> !$rose(flag_i[1]));

  assert_cmpb_flag_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i[2] |=> !$rose(flag_i[2]));

endmodule

bind tmr8_dual tmr8_dual_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (ctrl_q.mode),
  .tick_i    (tick),
  .load_i    (load),
  .cnt_i     (cnt),
  .down_i    (down),
  .top_i     (top),
  .top_hit_i (top_hit),
  .ocra_i    (ocr[0]),
  .pwr_i     (pwr_q),
  .evt_i     (evt),
  .flag_i    (flag_o)
);

// File: tb/tb_tmr8_dual.sv
`timescale 1ns/1ps
module tb_tmr8_dual;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       presc_tick = 1'b0;
  logic       ext_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] cnt_o;
  logic       wave_a, wave_b;
  logic [2:0] flag_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int presc_div = 1;
  int presc_ph = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  tmr8_dual dut (
    .clk_i(clk), .rst_ni(rst_n), .presc_tick_i(presc_tick), .ext_clk_i(ext_clk),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cnt_o(cnt_o), .wave_a_o(wave_a), .wave_b_o(wave_b), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model state
  int m_cnt, m_down, m_bufa, m_bufb, m_acta, m_actb, m_wa, m_wb;
  int m_flag, m_mask, m_pwr, m_ctrl, m_s1, m_s2, m_prev;

  function automatic int wave_next(int w, int s, int m, int pwm, int down);
    if (!m) return w;
    if (!pwm) begin
      if (s == 1) return 1 - w;
      if (s == 2) return 0;
      if (s == 3) return 1;
      return w;
    end
    if (s == 2) return down;
    if (s == 3) return 1 - down;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_down = 0; m_bufa = 0; m_bufb = 0; m_acta = 0; m_actb = 0;
      m_wa = 0; m_wb = 0; m_flag = 0; m_mask = 0; m_pwr = 0; m_ctrl = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      int mode, csel, sa, sb, tick, ld, st, pwm, top, ma, mb, ov, th, d, a, wr;
      int ncnt, ndown, nacta, nactb, ev;
      mode = m_ctrl & 3; csel = (m_ctrl >> 2) & 3;
      sa = (m_ctrl >> 4) & 3; sb = (m_ctrl >> 6) & 3;
      wr = wr_en; a = wr_addr; d = wr_data;
      case (csel)
        1: tick = presc_tick;
        2: tick = (m_s2 && !m_prev) ? 1 : 0;
        3: tick = (!m_s2 && m_prev) ? 1 : 0;
        default: tick = 0;
      endcase
      if (m_pwr) tick = 0;
      ld = (wr && a == 1) ? 1 : 0;
      st = tick && !ld;
      pwm = (mode >= 2) ? 1 : 0;
      top = (mode == 3) ? m_acta : 255;
      ma = st && m_cnt == m_acta;
      mb = st && m_cnt == m_actb;
      ov = st && (pwm ? (m_down && m_cnt == 0) : m_cnt == 255);
      th = st && pwm && m_cnt == top;
      ncnt = m_cnt; ndown = m_down;
      if (ld) ncnt = d;
      else if (tick) begin
        if (mode == 0) begin ncnt = (m_cnt + 1) % 256; ndown = 0; end
        else if (mode == 1) begin ncnt = (m_cnt == m_acta) ? 0 : m_cnt + 1; ndown = 0; end
        else if (top == 0) begin ncnt = 0; ndown = 0; end
        else if (!m_down) begin
          if (m_cnt >= top) begin ncnt = m_cnt - 1; ndown = 1; end
          else ncnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin ncnt = 1; ndown = 0; end
          else ncnt = m_cnt - 1;
        end
      end
      m_wa = wave_next(m_wa, sa, ma, pwm, m_down);
      m_wb = wave_next(m_wb, sb, mb, pwm, m_down);
      nacta = m_acta; nactb = m_actb;
      if (!pwm) begin
        nacta = (wr && a == 2) ? d : m_bufa;
        nactb = (wr && a == 3) ? d : m_bufb;
      end else if (th) begin
        nacta = m_bufa; nactb = m_bufb;
      end
      if (wr && a == 2) m_bufa = d;
      if (wr && a == 3) m_bufb = d;
      ev = (mb << 2) | (ma << 1) | ov;
      for (int b = 0; b < 3; b++) begin
        if (ev[b]) m_flag = m_flag | (1 << b);
        else if (wr && a == 5 && d[b]) m_flag = m_flag & ~(1 << b);
      end
      if (wr && a == 0) m_ctrl = d;
      if (wr && a == 4) m_mask = d & 7;
      if (wr && a == 6) m_pwr = d & 1;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
      m_cnt = ncnt; m_down = ndown; m_acta = nacta; m_actb = nactb;
    end
  end

  // prescaler strobe generator and per-cycle comparison
  always @(negedge clk) begin
    presc_ph = (presc_ph + 1) % presc_div;
    presc_tick = (presc_ph == 0);
    if (rst_n && checking && !done) begin
      chk(cur_req, "cnt", cnt_o, m_cnt);
      chk((((m_ctrl >> 4) & 3) >= 2 && (m_ctrl & 2)) ? "R6" : "R4", "wave_a", wave_a,
          (((m_ctrl >> 4) & 3) != 0) ? m_wa : 0);
      chk((((m_ctrl >> 6) & 3) >= 2 && (m_ctrl & 2)) ? "R6" : "R4", "wave_b", wave_b,
          (((m_ctrl >> 6) & 3) != 0) ? m_wb : 0);
      chk("R10", "flag", flag_o, m_flag);
      chk("R11", "irq", irq_o, m_flag & m_mask);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_toggle(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ext_clk = ~ext_clk;
      run(gap);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int snap;
    run(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cnt", cnt_o, 0);
    chk("R1", "wave", {wave_b, wave_a}, 0);
    chk("R1", "flag", flag_o, 0);
    chk("R1", "irq", irq_o, 0);
    checking = 1'b1;

    // R2 free-running with overflow, R11 masked request
    cur_req = "R2";
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h04);
    run(600);
    chk("R2", "ovf flag", flag_o[0], 1);
    chk("R11", "ovf irq", irq_o[0], 1);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h07);
    chk("R10", "flag cleared", flag_o, 0);
    wr(3'd4, 8'h00);

    // R3/R4 clear on compare, toggle on A, set then clear on B
    cur_req = "R3";
    wr(3'd2, 8'd9);
    wr(3'd3, 8'd4);
    wr(3'd1, 8'd0);
    wr(3'd0, 8'hD5);
    run(200);
    chk("R3", "cmpA flag", flag_o[1], 1);
    chk("R4", "wave_b set", wave_b, 1);
    cur_req = "R4";
    wr(3'd0, 8'h95);
    run(100);
    chk("R4", "wave_b cleared", wave_b, 0);

    // R8 sparse prescaler strobe
    cur_req = "R8";
    presc_div = 3;
    wr(3'd2, 8'd40);
    run(200);
    presc_div = 1;

    // R5/R6/R7 phase-correct, TOP fixed, compare rewrite mid-period
    cur_req = "R5";
    wr(3'd4, 8'h07);
    wr(3'd2, 8'h40);
    wr(3'd3, 8'h80);
    wr(3'd0, 8'hE6);
    run(600);
    cur_req = "R7";
    wr(3'd2, 8'h20);
    run(600);

    // R5 TOP from compare A, then rewrite TOP
    cur_req = "R5";
    wr(3'd2, 8'd20);
    wr(3'd3, 8'd7);
    wr(3'd0, 8'hE7);
    run(400);
    cur_req = "R7";
    wr(3'd2, 8'd30);
    run(300);

    // R8 external pin, both edge polarities
    cur_req = "R8";
    wr(3'd0, 8'h08);
    ext_toggle(40, 3);
    wr(3'd0, 8'h0C);
    ext_toggle(40, 2);

    // R9 power reduction holds counter
    cur_req = "R9";
    wr(3'd0, 8'h04);
    run(10);
    wr(3'd6, 8'h01);
    snap = cnt_o;
    run(50);
    chk("R9", "held cnt", cnt_o, snap);
    wr(3'd6, 8'h00);
    run(20);

    // R12 counter load while running
    cur_req = "R12";
    wr(3'd1, 8'h7E);
    run(30);
    wr(3'd1, 8'hFF);
    run(5);

    // R10 clears racing frequent events
    cur_req = "R10";
    wr(3'd2, 8'd2);
    wr(3'd3, 8'd1);
    wr(3'd0, 8'hD5);
    for (int i = 0; i < 40; i++) begin
      wr(3'd5, 8'h07);
      run(i % 3);
    end

    // R8 stopped source
    cur_req = "R8";
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h33);
    run(1);
    chk("R12", "loaded cnt", cnt_o, 8'h33);
    run(30);
    chk("R8", "stopped cnt", cnt_o, 8'h33);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule